// File: doc/BRIEF.md
# Write-Bypass Data Tenure Scheduler

This block sits on the master side of a split-transaction bus. The address pipeline hands it one pending data tenure at a time: a read or a write, with a tag and a burst length. It keeps these tenures in the order their address phases finished. When the bus grants the data phase, it picks one tenure, presents its tag and direction, and tracks its data beats until the tenure ends.

The normal choice is the oldest pending tenure. A write-first hint is sampled together with the grant. When the hint is active, the oldest pending write runs ahead of any older reads. Writes never pass other writes. An address retry that arrives before a tenure has started removes that tenure from the queue, and the address phase queues it again later. Only one data tenure is active at a time.

Top module: `tenure_sched`

## Requirements
- R1: While reset is low and on the first clock after it, the queue is empty, `enq_ready` is 1 and `act_valid` is 0.
- R2: A qualified grant with `wr_first` low, no active tenure and a non-empty queue starts the oldest pending entry. From the next clock, `act_valid` is 1 and `act_tag`, `act_is_wr` and `act_burst` show that entry.
- R3: A grant with `wr_first` high starts the oldest pending write (`is_wr`=1) when any write is pending, even if older reads are waiting.
- R4: Writes start in the order they were enqueued. A write never starts ahead of an older write.
- R5: A grant with `wr_first` high and no write pending starts the oldest read.
- R6: A grant with `wr_first` high and no read pending starts the oldest entry, so the order is unchanged.
- R7: An active tenure with `burst`=0 ends after 1 TA beat, and with `burst`=1 it ends after 4 TA beats. A TEA ends it at once. Clocks with neither TA nor TEA hold the tenure unchanged. `act_valid` drops on the clock after the ending beat.
- R8: A grant has no effect while a tenure is active, and none while the queue is empty.
- R9: `retry_valid` removes the oldest queued, not-yet-started entry whose tag equals `retry_tag`. The removal happens before the same clock's grant selection. The active tenure is never removed.
- R10: The queue holds DEPTH entries (default 4). `enq_ready` is 0 when DEPTH entries are queued, and `enq_valid` is then ignored.
- R11: An entry enqueued on the same clock as a grant cannot be picked by that grant. It joins the queue behind the entries already there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue a tenure from the address pipeline |
| enq_is_wr | input | 1 | 1 = write, 0 = read |
| enq_tag | input | 4 | Tag of the enqueued tenure |
| enq_burst | input | 1 | 1 = four beats, 0 = one beat |
| enq_ready | output | 1 | Queue can accept an entry |
| grant | input | 1 | Qualified data bus grant |
| wr_first | input | 1 | Write-first hint sampled with the grant |
| ta | input | 1 | Transfer acknowledge (one data beat) |
| tea | input | 1 | Transfer error, ends the tenure |
| retry_valid | input | 1 | Address retry for a queued tenure |
| retry_tag | input | 4 | Tag of the retried tenure |
| act_valid | output | 1 | A data tenure is in progress |
| act_is_wr | output | 1 | Direction of the active tenure |
| act_tag | output | 4 | Tag of the active tenure |
| act_burst | output | 1 | Burst length code of the active tenure |

## Verification
All results are due on the clock that samples their stimulus:
- A grant sampled at a rising edge shows on the `act_*` outputs right after that edge.
- A final TA or a TEA clears `act_valid` at that same edge.
- `enq_ready` follows the queue occupancy as of the latest edge.

The bench drives inputs at the falling edge. A behavioural queue model updates at each rising edge from the same inputs. The outputs are compared at the next falling edge, so every check looks exactly one edge after its stimulus. Directed sequences cover each ordering case. A long random run then mixes grants, hints, retries, wait states and errors.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  localparam int TAG_W      = 4;
  localparam int LONG_BEATS = 4;
  localparam int BEAT_W     = 3;

  typedef struct packed {
    logic             is_wr;
    logic [TAG_W-1:0] tag;
    logic             burst;
  } tenure_t;
endpackage

// File: rtl/tsched_first.sv
module tsched_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tsched_pick.sv
module tsched_pick #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] pend,
  input  logic [DEPTH-1:0] wr_mask,
  input  logic             wr_first,
  output logic             found,
  output logic             has_wr,
  output logic [IW-1:0]    idx
);
  logic          any_found;
  logic [IW-1:0] any_idx;
  logic [IW-1:0] wr_idx;

  tsched_first #(.N(DEPTH)) u_oldest (.req(pend),    .found(any_found), .idx(any_idx));
  tsched_first #(.N(DEPTH)) u_oldwr  (.req(wr_mask), .found(has_wr),    .idx(wr_idx));

  assign found = any_found;
  assign idx   = (wr_first && has_wr) ? wr_idx : any_idx;
endmodule

// File: rtl/tsched_active.sv
module tsched_active
  import tsched_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  tenure_t start_ent,
  input  logic    ta,
  input  logic    tea,
  output logic    act_valid,
  output tenure_t act_ent
);
  logic              v_q, v_n;
  tenure_t           e_q, e_n;
  logic [BEAT_W-1:0] left_q, left_n;
  logic              en;

  assign en = start | (v_q & (ta | tea));

  always_comb begin
    v_n    = v_q;
    e_n    = e_q;
    left_n = left_q;
    if (start) begin
      v_n    = 1'b1;
      e_n    = start_ent;
      left_n = start_ent.burst ? BEAT_W'(LONG_BEATS) : BEAT_W'(1);
    end else if (v_q) begin
      if (tea) begin
        v_n = 1'b0;
      end else if (ta) begin
        left_n = left_q - BEAT_W'(1);
        if (left_q == BEAT_W'(1)) v_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      e_q    <= '0;
      left_q <= '0;
    end else if (en) begin
      v_q    <= v_n;
      e_q    <= e_n;
      left_q <= left_n;
    end
  end

  assign act_valid = v_q;
  assign act_ent   = e_q;
endmodule

// File: rtl/tenure_sched.sv
module tenure_sched
  import tsched_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_is_wr,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic             enq_burst,
  output logic             enq_ready,
  input  logic             grant,
  input  logic             wr_first,
  input  logic             ta,
  input  logic             tea,
  input  logic             retry_valid,
  input  logic [TAG_W-1:0] retry_tag,
  output logic             act_valid,
  output logic             act_is_wr,
  output logic [TAG_W-1:0] act_tag,
  output logic             act_burst
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  tenure_t          q   [DEPTH];
  tenure_t          q_n [DEPTH];
  logic [CW-1:0]    cnt, cnt_n;
  logic [DEPTH-1:0] vld, tag_hit, rt_oh, keep1, wrm, sel_oh, keep2;
  logic             rt_found, sel_found, has_wr, start, enq_fire, q_en;
  logic [IW-1:0]    rt_idx, sel_idx;
  tenure_t          act_ent, new_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    assign vld[i]     = CW'(i) < cnt;
    assign tag_hit[i] = retry_valid && vld[i] && (q[i].tag == retry_tag);
    assign rt_oh[i]   = rt_found && (rt_idx == IW'(i));
    assign keep1[i]   = vld[i] && !rt_oh[i];
    assign wrm[i]     = keep1[i] && q[i].is_wr;
    assign sel_oh[i]  = start && (sel_idx == IW'(i));
    assign keep2[i]   = keep1[i] && !sel_oh[i];
  end

  tsched_first #(.N(DEPTH)) u_retry (.req(tag_hit), .found(rt_found), .idx(rt_idx));

  tsched_pick #(.DEPTH(DEPTH)) u_pick (
    .pend(keep1), .wr_mask(wrm), .wr_first(wr_first),
    .found(sel_found), .has_wr(has_wr), .idx(sel_idx)
  );

  assign start     = grant && !act_valid && sel_found;
  assign enq_ready = (cnt != CW'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign q_en      = enq_fire | rt_found | start;
  assign new_ent   = '{is_wr: enq_is_wr, tag: enq_tag, burst: enq_burst};

  // Compact surviving entries toward the head, then append.
  always_comb begin
    logic [CW-1:0] w;
    w = '0;
    for (int i = 0; i < DEPTH; i++) q_n[i] = q[i];
    for (int i = 0; i < DEPTH; i++) begin
      if (keep2[i]) begin
        q_n[w[IW-1:0]] = q[i];
        w = w + CW'(1);
      end
    end
    if (enq_fire) begin
      q_n[w[IW-1:0]] = new_ent;
      w = w + CW'(1);
    end
    cnt_n = w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (q_en) begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end
  end

  tsched_active u_active (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ent(q[sel_idx]),
    .ta(ta), .tea(tea), .act_valid(act_valid), .act_ent(act_ent)
  );

  assign act_is_wr = act_ent.is_wr;
  assign act_tag   = act_ent.tag;
  assign act_burst = act_ent.burst;
endmodule

// File: rtl/tsched_chk.sv
module tsched_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant,
  input logic          hint,
  input logic          ta,
  input logic          tea,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic          act_valid,
  input logic          act_is_wr,
  input logic [3:0]    act_tag,
  input logic [CW-1:0] cnt,
  input logic          has_wr,
  input logic          sel_found
);
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R10
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready) |=> (cnt <= $past(cnt)));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !ta && !tea) |=> (act_valid && $stable(act_tag) && $stable(act_is_wr)));

  // R7
  tea_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && tea) |=> !act_valid);

  // R3
  wr_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && hint && !act_valid && has_wr) |=> (act_valid && act_is_wr));

  // R8
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_valid) |-> $past(grant));

  // R8
  empty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !act_valid && !sel_found) |=> !act_valid);
endmodule

bind tenure_sched tsched_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .grant(grant), .hint(wr_first), .ta(ta), .tea(tea),
  .enq_valid(enq_valid), .enq_ready(enq_ready), .act_valid(act_valid),
  .act_is_wr(act_is_wr), .act_tag(act_tag), .cnt(cnt), .has_wr(has_wr),
  .sel_found(sel_found)
);

// File: tb/tenure_sched_tb_top.sv
`timescale 1ns/1ps
module tenure_sched_tb_top;
  localparam int DEPTH = 4;

  logic       clk, rst_n;
  logic       enq_valid, enq_is_wr, enq_burst, enq_ready;
  logic [3:0] enq_tag, retry_tag, act_tag;
  logic       grant, wr_first, ta, tea, retry_valid;
  logic       act_valid, act_is_wr, act_burst;

  tenure_sched #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_is_wr(enq_is_wr),
    .enq_tag(enq_tag), .enq_burst(enq_burst), .enq_ready(enq_ready),
    .grant(grant), .wr_first(wr_first), .ta(ta), .tea(tea),
    .retry_valid(retry_valid), .retry_tag(retry_tag), .act_valid(act_valid),
    .act_is_wr(act_is_wr), .act_tag(act_tag), .act_burst(act_burst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { bit wr; int tag; bit burst; } ment_t;
  ment_t mq[$];
  bit    m_act, m_wr, m_burst, m_ready;
  int    m_tag, m_left;
  int    n_vec, n_bad;
  string cur_req;

  // Behavioural reference, updated on each rising edge.
  always @(posedge clk) begin
    int sz0, p;
    if (!rst_n) begin
      mq.delete();
      m_act = 0; m_ready = 1; m_left = 0;
    end else begin
      sz0 = mq.size();
      if (retry_valid) begin
        for (int i = 0; i < mq.size(); i++)
          if (mq[i].tag == int'(retry_tag)) begin mq.delete(i); break; end
      end
      if (grant && !m_act && mq.size() > 0) begin
        p = 0;
        if (wr_first)
          for (int i = 0; i < mq.size(); i++) if (mq[i].wr) begin p = i; break; end
        m_act = 1; m_wr = mq[p].wr; m_tag = mq[p].tag; m_burst = mq[p].burst;
        m_left = mq[p].burst ? 4 : 1;
        mq.delete(p);
      end else if (m_act) begin
        if (tea) m_act = 0;
        else if (ta) begin
          m_left--;
          if (m_left == 0) m_act = 0;
        end
      end
      if (enq_valid && sz0 < DEPTH) mq.push_back('{enq_is_wr, int'(enq_tag), enq_burst});
      m_ready = mq.size() < DEPTH;
    end
  end

  task automatic chk(string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("act_valid", int'(act_valid), int'(m_act));
    chk("enq_ready", int'(enq_ready), int'(m_ready));
    if (m_act) begin
      chk("act_tag",   int'(act_tag),   m_tag);
      chk("act_is_wr", int'(act_is_wr), int'(m_wr));
      chk("act_burst", int'(act_burst), int'(m_burst));
    end
  endtask

  task automatic idle();
    enq_valid = 0; enq_is_wr = 0; enq_tag = 0; enq_burst = 0;
    grant = 0; wr_first = 0; ta = 0; tea = 0; retry_valid = 0; retry_tag = 0;
  endtask

  task automatic enq(bit wr, int tag, bit burst);
    enq_valid = 1; enq_is_wr = wr; enq_tag = 4'(tag); enq_burst = burst;
    tick(); idle();
  endtask

  task automatic gnt(bit hint);
    grant = 1; wr_first = hint;
    tick(); idle();
  endtask

  task automatic beat(bit a, bit e);
    ta = a; tea = e;
    tick(); idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0;
    cur_req = "R1";
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();                                // R1 reset state

    cur_req = "R10";
    enq(0, 1, 0); enq(1, 2, 1); enq(0, 3, 0); enq(1, 4, 0);
    enq(1, 5, 0);                          // R10 ignored while full

    cur_req = "R2";
    gnt(0);                                // oldest: read 1
    cur_req = "R7";
    beat(1, 0);                            // single beat ends it

    cur_req = "R3";
    gnt(1);                                // write 2 passes read 3
    cur_req = "R8";
    grant = 1; ta = 1; tick(); idle();     // grant ignored while active
    cur_req = "R7";
    beat(0, 0); beat(1, 0); beat(0, 0); beat(1, 0); beat(1, 0);

    cur_req = "R4";
    gnt(1);                                // write 4, in write order
    cur_req = "R7";
    beat(0, 1);                            // error ends it

    cur_req = "R5";
    gnt(1);                                // only read 3 left
    beat(1, 0);

    cur_req = "R6";
    enq(1, 6, 0); enq(1, 7, 1);
    gnt(1);                                // no read: oldest write 6
    beat(1, 0);

    cur_req = "R9";
    enq(0, 8, 0); enq(0, 9, 1);
    retry_valid = 1; retry_tag = 4'd7; grant = 1;
    tick(); idle();                        // 7 removed first, read 8 starts
    beat(1, 0);
    retry_valid = 1; retry_tag = 4'd9; tick(); idle();
    gnt(0);                                // queue empty: nothing starts

    cur_req = "R11";
    enq_valid = 1; enq_is_wr = 1; enq_tag = 4'd10; enq_burst = 0; grant = 1;
    tick(); idle();                        // not eligible for that grant
    gnt(0);
    beat(1, 0);

    cur_req = "R4";
    for (int n = 0; n < 4000; n++) begin
      enq_valid   = ($urandom_range(1) == 1);
      enq_is_wr   = ($urandom_range(1) == 1);
      enq_tag     = 4'($urandom_range(15));
      enq_burst   = ($urandom_range(1) == 1);
      grant       = ($urandom_range(3) == 0);
      wr_first    = ($urandom_range(1) == 1);
      ta          = ($urandom_range(9) < 6);
      tea         = ($urandom_range(19) == 0);
      retry_valid = ($urandom_range(19) == 0);
      retry_tag   = 4'($urandom_range(15));
      tick();
    end
    idle();
    tick();
    finish_run();
  end
endmodule